// File: doc/BRIEF.md
# CAN Frame-Event Timestamp Timer

This block is a free-running 16-bit time base for a CAN controller. It records the count when frame boundaries appear on the bus. Software programs it through a small write port that reaches two registers. The first is a 16-bit control register. Its bit 15 starts the timer. Its bit 14 arms a capture register that latches the count at every start of frame. Its bit 13 chooses whether the receive timestamp is taken at start of frame or at end of frame. The second register is a compare value.

The frame logic supplies single-cycle start-of-frame and end-of-frame pulses. It also supplies a pulse for when a received identifier hits a mailbox that carries the special compare flag. When control bit 9 is set, that pulse clears bit 14 in hardware, so later frames leave the captured value alone. Clearing bit 15 does not stop the timer at once. The counter keeps running until its next wrap or compare match, and then it halts.

Top module: `can_stamp_timer`

## Requirements
- R1: After synchronous reset, the control register, the count, the capture register and the timestamp all read 0. The strobes and flags are low.
- R2: A write with `wr_addr`=0 loads all 16 control bits, and they read back unchanged on `ctrl_o`. With bit 15 at 0 and the timer idle, the count does not move.
- R3: A control write is seen on `ctrl_o` after the clock edge that takes it. While bit 15 is 1, the count rises by one on each following cycle.
- R4: After bit 15 is cleared, the count keeps rising until a compare match or a wrap occurs. After that event it holds its value.
- R5: The count wraps from 0xFFFF to 0, and `ovf_o` is high for one cycle in which the count reads 0.
- R6: While bit 14 is 1, each `sof_i` pulse loads `cap_o` with the count from the cycle of the pulse.
- R7: While bit 14 is 0, `sof_i` leaves `cap_o` unchanged.
- R8: An `id_hit_i` pulse while bit 9 is 1 clears bit 14 and leaves every other bit as it was.
- R9: An `id_hit_i` pulse while bit 9 is 0 has no effect on the control register.
- R10: If the hardware clear of R8 and a software write that sets bit 14 fall in the same cycle, bit 14 ends at 0 and the rest of the written value is kept.
- R11: With bit 13 at 0, only `sof_i` produces a timestamp. With bit 13 at 1, only `eof_i` does. Each timestamp raises `stamp_vld_o` for one cycle.
- R12: A timestamp or capture holds the count from before the increment in the cycle of the triggering pulse.
- R13: A write with `wr_addr`=1 sets the compare value. `match_o` is high for one cycle after each cycle in which the running count equals it, and this happens whether bit 15 is set or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects compare |
| wr_data | input | 16 | Write data |
| sof_i | input | 1 | Start-of-frame pulse |
| eof_i | input | 1 | End-of-frame pulse |
| id_hit_i | input | 1 | Received ID hit a flagged mailbox |
| ctrl_o | output | 16 | Control register readback |
| count_o | output | 16 | Current count |
| cap_o | output | 16 | Capture register |
| stamp_o | output | 16 | Receive timestamp |
| stamp_vld_o | output | 1 | Timestamp strobe |
| ovf_o | output | 1 | Overflow pulse |
| match_o | output | 1 | Compare-match pulse |

## Verification
The hardest case to reach is a deferred stop that ends on the wrap rather than on a compare match. To get there, the stimulus first stops the timer on a match at a known count. It then restarts the timer so that the count is already above the compare value, and clears bit 15 straight away. The count must then climb through some 65,000 values, and the bench waits for `ovf_o` and checks that the count stays at zero. The hardware-over-software collision of R10 is reached by driving the write and the hit pulse on the same cycle.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int CTRL_W   = 16;
  localparam int BIT_RUN  = 15;
  localparam int BIT_CAP  = 14;
  localparam int BIT_TSEL = 13;
  localparam int BIT_MODE = 9;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_CMP  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cts_ctrl_reg.sv
module cts_ctrl_reg
  import cts_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              id_hit,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic auto_clr;
  assign auto_clr = id_hit & ctrl_q[BIT_MODE];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data;
      // hardware clear is placed last so it overrides a same-cycle write
      if (auto_clr) ctrl_q[BIT_CAP] <= 1'b0;
    end
  end
endmodule

// File: rtl/cts_counter.sv
module cts_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_bit,
  input  logic         wr_cmp,
  input  logic [W-1:0] cmp_data,
  output logic [W-1:0] count_q,
  output logic         ovf_q,
  output logic         match_q
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cmp_q;
  logic         drain_q;
  logic         active, at_max, at_cmp, stop_ev;

  assign active  = run_bit | drain_q;
  assign at_max  = (count_q == CNT_MAX);
  assign at_cmp  = (count_q == cmp_q);
  assign stop_ev = active & (at_max | at_cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= CNT_MAX;
    end else if (wr_cmp) begin
      cmp_q <= cmp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      drain_q <= 1'b0;
      ovf_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      if (active) count_q <= count_q + 1'b1;
      drain_q <= run_bit | (drain_q & ~stop_ev);
      ovf_q   <= active & at_max;
      match_q <= active & at_cmp;
    end
  end
endmodule

// File: rtl/cts_capture.sv
module cts_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic         ts_on_eof,
  input  logic         sof,
  input  logic         eof,
  input  logic [W-1:0] count,
  output logic [W-1:0] cap_q,
  output logic [W-1:0] stamp_q,
  output logic         stamp_vld_q
);
  logic ts_trig;
  assign ts_trig = ts_on_eof ? eof : sof;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q       <= '0;
      stamp_q     <= '0;
      stamp_vld_q <= 1'b0;
    end else begin
      if (cap_en && sof) cap_q <= count;
      if (ts_trig) stamp_q <= count;
      stamp_vld_q <= ts_trig;
    end
  end
endmodule

// File: rtl/can_stamp_timer.sv
module can_stamp_timer
  import cts_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              id_hit_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic [CNT_W-1:0]  stamp_o,
  output logic              stamp_vld_o,
  output logic              ovf_o,
  output logic              match_o
);
  logic wr_ctrl, wr_cmp;
  assign wr_ctrl = wr_en & (wr_addr == REG_CTRL);
  assign wr_cmp  = wr_en & (wr_addr == REG_CMP);

  cts_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_ctrl),
    .wr_data (wr_data),
    .id_hit  (id_hit_i),
    .ctrl_q  (ctrl_o)
  );

  cts_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run_bit  (ctrl_o[BIT_RUN]),
    .wr_cmp   (wr_cmp),
    .cmp_data (wr_data[CNT_W-1:0]),
    .count_q  (count_o),
    .ovf_q    (ovf_o),
    .match_q  (match_o)
  );

  cts_capture #(.W(CNT_W)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .cap_en      (ctrl_o[BIT_CAP]),
    .ts_on_eof   (ctrl_o[BIT_TSEL]),
    .sof         (sof_i),
    .eof         (eof_i),
    .count       (count_o),
    .cap_q       (cap_o),
    .stamp_q     (stamp_o),
    .stamp_vld_q (stamp_vld_o)
  );
endmodule

// File: rtl/can_stamp_timer_chk.sv
module can_stamp_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sof_i,
  input logic             id_hit_i,
  input logic [15:0]      ctrl_o,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] cap_o,
  input logic [CNT_W-1:0] stamp_o,
  input logic             stamp_vld_o,
  input logic             ovf_o,
  input logic             match_o
);
  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_o[15] |=> count_o == CNT_W'($past(count_o) + 1'b1));

  p_stop_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((ovf_o || match_o) && !ctrl_o[15] && !$past(ctrl_o[15])) |=> $stable(count_o));

  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> count_o == '0);

  p_cap_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(sof_i && ctrl_o[14]) |=> $stable(cap_o));

  p_self_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (id_hit_i && ctrl_o[9]) |=> !ctrl_o[14]);

  p_stamp_prior_r12: assert property (@(posedge clk) disable iff (rst)
    stamp_vld_o |-> stamp_o == $past(count_o));

  p_match_single_r13: assert property (@(posedge clk) disable iff (rst)
    match_o |=> !match_o);
endmodule

bind can_stamp_timer can_stamp_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/can_stamp_timer_tb.sv
module can_stamp_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        sof_i = 1'b0, eof_i = 1'b0, id_hit_i = 1'b0;
  logic [15:0] ctrl_o, count_o, cap_o, stamp_o;
  logic        stamp_vld_o, ovf_o, match_o;

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  logic m_cap = 1'b0, m_tsel = 1'b0;
  logic [15:0] m_capval = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_stamp_timer u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor: every timestamp strobe must match the head of the queue
  always @(negedge clk) begin
    if (!rst && stamp_vld_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R11 unexpected stamp", stamp_o, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(stamp_o == e, "R12 stamp value", stamp_o, e);
      end
    end
  end

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!a) begin m_cap = d[14]; m_tsel = d[13]; end
  endtask

  task automatic pulse_sof();
    logic [15:0] e;
    @(negedge clk);
    e = count_o;
    sof_i = 1'b1;
    if (!m_tsel) exp_q.push_back(e);
    if (m_cap) m_capval = e;
    @(negedge clk);
    sof_i = 1'b0;
    chk(cap_o == m_capval, m_cap ? "R6 capture" : "R7 capture hold", cap_o, m_capval);
  endtask

  task automatic pulse_eof();
    @(negedge clk);
    eof_i = 1'b1;
    if (m_tsel) exp_q.push_back(count_o);
    @(negedge clk);
    eof_i = 1'b0;
  endtask

  task automatic pulse_hit();
    @(negedge clk);
    id_hit_i = 1'b1;
    @(negedge clk);
    id_hit_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_up();
    end
  end

  initial begin
    logic [15:0] a, c;
    bit seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(ctrl_o == 0 && count_o == 0, "R1 reset ctrl/count", {ctrl_o, count_o}, 0);
    chk(cap_o == 0 && stamp_o == 0 && !stamp_vld_o && !ovf_o && !match_o,
        "R1 reset outputs", cap_o, 0);

    // R2
    wr(1'b0, 16'h1AB5);
    chk(ctrl_o == 16'h1AB5, "R2 readback", ctrl_o, 16'h1AB5);
    repeat (5) @(negedge clk);
    chk(count_o == 0, "R2 idle count", count_o, 0);

    // R3
    wr(1'b0, 16'h8000);
    chk(count_o == 0, "R3 start latency", count_o, 0);
    a = count_o;
    repeat (10) @(negedge clk);
    chk(count_o == 16'(a + 10), "R3 counting", count_o, 16'(a + 10));

    // R13 match while running
    c = 16'(count_o + 30);
    wr(1'b1, c);
    seen = 0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (match_o) seen = 1;
    end
    chk(seen && count_o == 16'(c + 1), "R13 match pulse", count_o, 16'(c + 1));
    @(negedge clk);
    chk(!match_o, "R13 match one cycle", match_o, 0);
    chk(count_o == 16'(c + 2), "R13 keeps running", count_o, 16'(c + 2));

    // R4 deferred stop on match
    c = 16'(count_o + 40);
    wr(1'b1, c);
    wr(1'b0, 16'h0000);
    a = count_o;
    repeat (3) @(negedge clk);
    chk(count_o == 16'(a + 3), "R4 runs after clear", count_o, 16'(a + 3));
    seen = 0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (match_o) seen = 1;
    end
    chk(seen && count_o == 16'(c + 1), "R4 stop point", count_o, 16'(c + 1));
    repeat (10) @(negedge clk);
    chk(count_o == 16'(c + 1), "R4 holds", count_o, 16'(c + 1));

    // R5 deferred stop on wrap
    wr(1'b0, 16'h8000);
    wr(1'b0, 16'h0000);
    seen = 0;
    for (int i = 0; i < 70000 && !seen; i++) begin
      @(negedge clk);
      if (ovf_o) seen = 1;
      if (match_o) chk(0, "R5 stray match", count_o, 0);
    end
    chk(seen && count_o == 0, "R5 wrap to zero", count_o, 0);
    @(negedge clk);
    chk(!ovf_o, "R5 ovf one cycle", ovf_o, 0);
    repeat (5) @(negedge clk);
    chk(count_o == 0, "R5 holds after wrap", count_o, 0);

    // R6 / R11 / R12 capture and SOF stamps
    wr(1'b0, 16'hC000);
    repeat (7) @(negedge clk);
    pulse_sof();
    repeat (13) @(negedge clk);
    pulse_sof();
    pulse_eof();                 // R11: ignored with bit 13 at 0
    wr(1'b0, 16'hE000);
    pulse_sof();                 // R11: capture yes, stamp no
    repeat (4) @(negedge clk);
    pulse_eof();
    // R7
    wr(1'b0, 16'hA000);
    pulse_sof();
    // R8
    wr(1'b0, 16'hC200);
    pulse_hit();
    chk(ctrl_o == 16'h8200, "R8 self clear", ctrl_o, 16'h8200);
    m_cap = 1'b0;
    pulse_sof();
    // R9
    wr(1'b0, 16'hC000);
    pulse_hit();
    chk(ctrl_o == 16'hC000, "R9 hit ignored", ctrl_o, 16'hC000);
    pulse_sof();
    // R10
    wr(1'b0, 16'h8200);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 16'hC200; id_hit_i = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; id_hit_i = 1'b0;
    chk(ctrl_o == 16'h8200, "R10 clear beats write", ctrl_o, 16'h8200);
    m_cap = 1'b0;
    pulse_sof();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all stamps seen", exp_q.size(), 0);
    done = 1;
    finish_up();
  end
endmodule